// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits on the host side of a byte-wide parallel flash bus. It runs one of two operations: programming a single byte, or erasing a set of sectors given as a bit mask. For each, it writes the unlock and command cycles with counted write-strobe timing. It then waits the write recovery time and polls data bit 7 until the device reports completion. Each request ends with a one-cycle done pulse and a result code.

A request comes in on a valid/ready port. The request carries the operation, the target address, the data byte, the sector mask and a bus mode. In hold mode the sequencer keeps the polling address on the bus for the whole operation. In release mode the address pins are let go between bus cycles. The saved address is then driven again for every status read. A poll limit and a host abort input both end the operation with a reset command write, which puts the device back into read mode.

Top module: `flash_op_seq`

## Requirements
- R1: A program request issues exactly four write cycles, in this order: address 0x555 data 0xAA, address 0x2AA data 0x55, address 0x555 data 0xA0, then the request address with the request data.
- R2: An erase request issues address 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA and 0x2AA/0x55. It then issues one write of data 0x30 at each selected sector's base address, in ascending sector index. Mask bit i selects sector i, whose base address is i shifted left by SEC_SHIFT.
- R3: In every write cycle, address and data are driven for T_SU cycles before fl_we_n falls. fl_we_n stays low for exactly T_WP cycles. Address and data are held for T_H cycles after fl_we_n rises. fl_we_n and fl_oe_n are never low together.
- R4: The sector-erase writes run back to back. Successive fl_we_n rising edges in that phase are exactly T_SU+T_WP+T_H+1 cycles apart, which keeps them inside the device's erase join window.
- R5: At least T_WR cycles pass between the rising fl_we_n of the last command write and the first fall of fl_oe_n.
- R6: A program operation polls at the request address. It completes with result 0 (pass) on the first read whose bit 7 equals bit 7 of the programmed data.
- R7: An erase operation polls at the base address of the lowest selected sector. It completes with result 0 on the first read with bit 7 equal to 1.
- R8: During the polling phase in hold mode, fl_addr_oe stays high with the polling address on fl_addr. In release mode, fl_addr_oe is low whenever no bus cycle is in progress.
- R9: After MAX_POLLS reads with no match, the sequencer writes data 0xF0 at address 0. It then completes with result 1 (timeout).
- R10: A pulse on cmd_abort while a request is running causes a 0xF0 write at address 0 once the current bus cycle ends, followed by completion with result 2 (aborted). A pulse while idle has no effect.
- R11: done is high for exactly one cycle per request. cmd_ready is high only while idle, so a request presented while busy is not taken.
- R12: An erase request with an empty mask completes with result 0 and no bus cycle.
- R13: After reset, fl_we_n and fl_oe_n are high, fl_addr_oe, fl_dq_oe and done are low, and cmd_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Request accepted this cycle when high with cmd_valid |
| cmd_erase | input | 1 | 1 = erase sectors, 0 = program byte |
| cmd_hold | input | 1 | 1 = keep address on the bus, 0 = release between cycles |
| cmd_addr | input | AW | Program address |
| cmd_data | input | 8 | Program data |
| cmd_sectors | input | NSEC | Sector selection mask for erase |
| cmd_abort | input | 1 | Abort the running request |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 pass, 1 timeout, 2 aborted; valid with done |
| fl_addr | output | AW | Flash address bus |
| fl_addr_oe | output | 1 | Address bus driven |
| fl_dq_out | output | 8 | Flash write data |
| fl_dq_oe | output | 1 | Data bus driven |
| fl_dq_in | input | 8 | Flash read data |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_oe_n | output | 1 | Output enable, active low |

## Verification
The bench uses T_SU=2, T_WP=3, T_H=1, T_RD=2, T_WR=6, T_GAP=3 and MAX_POLLS=5. With these values a whole operation takes a few hundred cycles. The poll limit is reached by a device that stays busy, and strobe widths of different lengths show off-by-one errors in each phase. Sectors are 4 KiB apart on a 16-bit address with eight sectors. An erase mask with gaps then checks both the ascending order and the choice of polling sector.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        RES_PASS    = 2'd0,
        RES_TIMEOUT = 2'd1,
        RES_ABORT   = 2'd2
    } result_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SU,
        PH_LOW,
        PH_HOLD,
        PH_RD
    } phase_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CMD,
        S_RECOV,
        S_PREAD,
        S_PWAIT,
        S_GAP,
        S_RST,
        S_RSTW,
        S_FIN
    } seq_e;

    localparam logic [7:0] D_KEY1  = 8'hAA;
    localparam logic [7:0] D_KEY2  = 8'h55;
    localparam logic [7:0] D_PROG  = 8'hA0;
    localparam logic [7:0] D_ERASE = 8'h80;
    localparam logic [7:0] D_SECT  = 8'h30;
    localparam logic [7:0] D_RESET = 8'hF0;
    localparam int unsigned A_KEY1 = 32'h555;
    localparam int unsigned A_KEY2 = 32'h2AA;

endpackage

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle
    import flash_seq_pkg::*;
#(
    parameter int AW   = 16,
    parameter int T_SU = 2,
    parameter int T_WP = 4,
    parameter int T_H  = 2,
    parameter int T_RD = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_rd,
    input  logic [AW-1:0] start_addr,
    input  logic [7:0]    start_data,
    output logic          idle,
    output logic          cyc_done,
    output logic          drive,
    output logic          dq_oe,
    output logic          we_n,
    output logic          oe_n,
    output logic [AW-1:0] addr_o,
    output logic [7:0]    data_o
);

    localparam int TM1 = (T_SU > T_WP) ? T_SU : T_WP;
    localparam int TM2 = (T_H > T_RD) ? T_H : T_RD;
    localparam int TMAX = (TM1 > TM2) ? TM1 : TM2;
    localparam int CW = $clog2(TMAX + 1);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
        logic [AW-1:0] addr;
        logic [7:0]    data;
    } cyc_t;

    cyc_t cur_q, nxt_d;

    always_comb begin
        nxt_d    = cur_q;
        cyc_done = 1'b0;
        unique case (cur_q.ph)
            PH_IDLE: begin
                if (start) begin
                    nxt_d.addr = start_addr;
                    nxt_d.data = start_data;
                    if (start_rd) begin
                        nxt_d.ph  = PH_RD;
                        nxt_d.cnt = CW'(T_RD - 1);
                    end else begin
                        nxt_d.ph  = PH_SU;
                        nxt_d.cnt = CW'(T_SU - 1);
                    end
                end
            end
            PH_SU: begin
                if (cur_q.cnt == '0) begin
                    nxt_d.ph  = PH_LOW;
                    nxt_d.cnt = CW'(T_WP - 1);
                end else begin
                    nxt_d.cnt = cur_q.cnt - 1'b1;
                end
            end
            PH_LOW: begin
                if (cur_q.cnt == '0) begin
                    nxt_d.ph  = PH_HOLD;
                    nxt_d.cnt = CW'(T_H - 1);
                end else begin
                    nxt_d.cnt = cur_q.cnt - 1'b1;
                end
            end
            PH_HOLD, PH_RD: begin
                if (cur_q.cnt == '0) begin
                    cyc_done = 1'b1;
                    nxt_d.ph = PH_IDLE;
                end else begin
                    nxt_d.cnt = cur_q.cnt - 1'b1;
                end
            end
            default: nxt_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{ph: PH_IDLE, cnt: '0, addr: '0, data: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign idle   = (cur_q.ph == PH_IDLE);
    assign drive  = (cur_q.ph != PH_IDLE);
    assign dq_oe  = (cur_q.ph == PH_SU) || (cur_q.ph == PH_LOW) || (cur_q.ph == PH_HOLD);
    assign we_n   = (cur_q.ph != PH_LOW);
    assign oe_n   = (cur_q.ph != PH_RD);
    assign addr_o = cur_q.addr;
    assign data_o = cur_q.data;

endmodule

// File: rtl/flash_sector_pick.sv
module flash_sector_pick #(
    parameter int NSEC = 8,
    parameter int IW   = $clog2(NSEC)
) (
    input  logic [NSEC-1:0] mask,
    output logic            any,
    output logic [IW-1:0]   idx
);

    always_comb begin
        any = |mask;
        idx = '0;
        for (int i = NSEC - 1; i >= 0; i--) begin
            if (mask[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq
    import flash_seq_pkg::*;
#(
    parameter int AW        = 16,
    parameter int NSEC      = 8,
    parameter int SEC_SHIFT = 12,
    parameter int T_SU      = 2,
    parameter int T_WP      = 4,
    parameter int T_H       = 2,
    parameter int T_RD      = 3,
    parameter int T_WR      = 750,
    parameter int T_GAP     = 16,
    parameter int MAX_POLLS = 4096
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    output logic            cmd_ready,
    input  logic            cmd_erase,
    input  logic            cmd_hold,
    input  logic [AW-1:0]   cmd_addr,
    input  logic [7:0]      cmd_data,
    input  logic [NSEC-1:0] cmd_sectors,
    input  logic            cmd_abort,
    output logic            done,
    output logic [1:0]      result,
    output logic [AW-1:0]   fl_addr,
    output logic            fl_addr_oe,
    output logic [7:0]      fl_dq_out,
    output logic            fl_dq_oe,
    input  logic [7:0]      fl_dq_in,
    output logic            fl_we_n,
    output logic            fl_oe_n
);

    localparam int IW   = $clog2(NSEC);
    localparam int WMAX = (T_WR > T_GAP) ? T_WR : T_GAP;
    localparam int WC   = $clog2(WMAX + 1);
    localparam int PC   = $clog2(MAX_POLLS + 1);
    localparam logic [2:0] STEP_SECT = 3'd5;

    typedef struct packed {
        seq_e          state;
        logic          erase;
        logic          hold;
        logic [AW-1:0] paddr;
        logic [7:0]    pdata;
        logic [AW-1:0] poll_addr;
        logic [NSEC-1:0] mask;
        logic [2:0]    step;
        logic [PC-1:0] polls;
        logic [WC-1:0] wcnt;
        result_e       res;
        logic          abort_pend;
        logic          exp_b7;
    } seq_t;

    seq_t seq_q, seq_d;

    logic          bc_start, bc_rd;
    logic [AW-1:0] bc_addr;
    logic [7:0]    bc_data;
    logic          bc_idle, bc_done, bc_drive, bc_dq_oe, bc_we_n, bc_oe_n;
    logic [AW-1:0] bc_addr_o;
    logic [7:0]    bc_data_o;

    logic          new_any, cur_any;
    logic [IW-1:0] new_idx, cur_idx;
    logic          all_issued;
    logic          unused_dq;
    logic          mode_hold;
    logic          sect_phase;

    assign unused_dq = ^fl_dq_in[6:0];

    function automatic logic [AW-1:0] sect_base(input logic [IW-1:0] i);
        return AW'(i) << SEC_SHIFT;
    endfunction

    flash_sector_pick #(.NSEC(NSEC), .IW(IW)) u_pick_new (
        .mask (cmd_sectors),
        .any  (new_any),
        .idx  (new_idx)
    );

    flash_sector_pick #(.NSEC(NSEC), .IW(IW)) u_pick_cur (
        .mask (seq_q.mask),
        .any  (cur_any),
        .idx  (cur_idx)
    );

    flash_bus_cycle #(
        .AW(AW), .T_SU(T_SU), .T_WP(T_WP), .T_H(T_H), .T_RD(T_RD)
    ) u_cyc (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (bc_start),
        .start_rd   (bc_rd),
        .start_addr (bc_addr),
        .start_data (bc_data),
        .idle       (bc_idle),
        .cyc_done   (bc_done),
        .drive      (bc_drive),
        .dq_oe      (bc_dq_oe),
        .we_n       (bc_we_n),
        .oe_n       (bc_oe_n),
        .addr_o     (bc_addr_o),
        .data_o     (bc_data_o)
    );

    always_comb begin
        if (seq_q.erase) begin
            all_issued = (seq_q.step == STEP_SECT) && !cur_any;
        end else begin
            all_issued = (seq_q.step == 3'd4);
        end
    end

    always_comb begin
        seq_d    = seq_q;
        bc_start = 1'b0;
        bc_rd    = 1'b0;
        bc_addr  = '0;
        bc_data  = '0;

        if ((seq_q.state != S_IDLE) && cmd_abort) begin
            seq_d.abort_pend = 1'b1;
        end

        unique case (seq_q.state)
            S_IDLE: begin
                seq_d.abort_pend = 1'b0;
                if (cmd_valid) begin
                    seq_d.erase = cmd_erase;
                    seq_d.hold  = cmd_hold;
                    seq_d.paddr = cmd_addr;
                    seq_d.pdata = cmd_data;
                    seq_d.mask  = cmd_sectors;
                    seq_d.step  = 3'd0;
                    seq_d.polls = '0;
                    seq_d.res   = RES_PASS;
                    if (cmd_erase) begin
                        seq_d.poll_addr = sect_base(new_idx);
                        seq_d.exp_b7    = 1'b1;
                        seq_d.state     = new_any ? S_CMD : S_FIN;
                    end else begin
                        seq_d.poll_addr = cmd_addr;
                        seq_d.exp_b7    = cmd_data[7];
                        seq_d.state     = S_CMD;
                    end
                end
            end
            S_CMD: begin
                if (bc_idle) begin
                    if (seq_q.abort_pend) begin
                        seq_d.state = S_RST;
                        seq_d.res   = RES_ABORT;
                    end else if (all_issued) begin
                        seq_d.state = S_RECOV;
                        seq_d.wcnt  = WC'(T_WR - 1);
                    end else begin
                        bc_start = 1'b1;
                        if (seq_q.step != STEP_SECT) begin
                            seq_d.step = seq_q.step + 1'b1;
                        end
                        unique case (seq_q.step)
                            3'd0: begin bc_addr = AW'(A_KEY1); bc_data = D_KEY1; end
                            3'd1: begin bc_addr = AW'(A_KEY2); bc_data = D_KEY2; end
                            3'd2: begin
                                bc_addr = AW'(A_KEY1);
                                bc_data = seq_q.erase ? D_ERASE : D_PROG;
                            end
                            3'd3: begin
                                if (seq_q.erase) begin
                                    bc_addr = AW'(A_KEY1);
                                    bc_data = D_KEY1;
                                end else begin
                                    bc_addr = seq_q.paddr;
                                    bc_data = seq_q.pdata;
                                end
                            end
                            3'd4: begin bc_addr = AW'(A_KEY2); bc_data = D_KEY2; end
                            default: begin
                                bc_addr = sect_base(cur_idx);
                                bc_data = D_SECT;
                                seq_d.mask[cur_idx] = 1'b0;
                            end
                        endcase
                    end
                end
            end
            S_RECOV, S_GAP: begin
                if (seq_q.abort_pend) begin
                    seq_d.state = S_RST;
                    seq_d.res   = RES_ABORT;
                end else if (seq_q.wcnt == '0) begin
                    seq_d.state = S_PREAD;
                end else begin
                    seq_d.wcnt = seq_q.wcnt - 1'b1;
                end
            end
            S_PREAD: begin
                if (bc_idle) begin
                    bc_start    = 1'b1;
                    bc_rd       = 1'b1;
                    bc_addr     = seq_q.poll_addr;
                    seq_d.state = S_PWAIT;
                end
            end
            S_PWAIT: begin
                if (bc_done) begin
                    if (fl_dq_in[7] == seq_q.exp_b7) begin
                        seq_d.state = S_FIN;
                        seq_d.res   = RES_PASS;
                    end else if (seq_q.polls == PC'(MAX_POLLS - 1)) begin
                        seq_d.state = S_RST;
                        seq_d.res   = RES_TIMEOUT;
                    end else if (seq_q.abort_pend) begin
                        seq_d.state = S_RST;
                        seq_d.res   = RES_ABORT;
                    end else begin
                        seq_d.polls = seq_q.polls + 1'b1;
                        seq_d.state = S_GAP;
                        seq_d.wcnt  = WC'(T_GAP - 1);
                    end
                end
            end
            S_RST: begin
                if (bc_idle) begin
                    bc_start    = 1'b1;
                    bc_addr     = '0;
                    bc_data     = D_RESET;
                    seq_d.state = S_RSTW;
                end
            end
            S_RSTW: begin
                if (bc_done) seq_d.state = S_FIN;
            end
            S_FIN: begin
                seq_d.state = S_IDLE;
            end
            default: seq_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: S_IDLE, erase: 1'b0, hold: 1'b0, paddr: '0, pdata: '0,
                       poll_addr: '0, mask: '0, step: '0, polls: '0, wcnt: '0,
                       res: RES_PASS, abort_pend: 1'b0, exp_b7: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign mode_hold  = seq_q.hold && (seq_q.state != S_IDLE) && (seq_q.state != S_FIN);
    assign sect_phase = (seq_q.state == S_CMD) && seq_q.erase && (seq_q.step == STEP_SECT);

    assign cmd_ready  = (seq_q.state == S_IDLE);
    assign done       = (seq_q.state == S_FIN);
    assign result     = seq_q.res;
    assign fl_addr_oe = bc_drive || mode_hold;
    assign fl_addr    = bc_drive ? bc_addr_o : (mode_hold ? seq_q.poll_addr : '0);
    assign fl_dq_oe   = bc_dq_oe;
    assign fl_dq_out  = bc_dq_oe ? bc_data_o : '0;
    assign fl_we_n    = bc_we_n;
    assign fl_oe_n    = bc_oe_n;

endmodule

// File: rtl/flash_op_seq_chk.sv
module flash_op_seq_chk #(
    parameter int T_WR      = 750,
    parameter int ERASE_WIN = 6250
) (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic cmd_ready,
    input logic done,
    input logic fl_we_n,
    input logic fl_oe_n,
    input logic fl_dq_oe,
    input logic fl_addr_oe,
    input logic mode_hold,
    input logic sect_phase
);

    int unsigned since_we;
    int unsigned win_cnt;
    logic        we_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_we <= 0;
            win_cnt  <= 0;
            we_q     <= 1'b1;
        end else begin
            we_q <= fl_we_n;
            if (fl_we_n && !we_q) since_we <= 0;
            else if (since_we < T_WR) since_we <= since_we + 1;
            if (!sect_phase || (fl_we_n && !we_q)) win_cnt <= 0;
            else win_cnt <= win_cnt + 1;
        end
    end

    // R3: strobes never overlap
    a_r3_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_we_n && !fl_oe_n));

    // R3: bus driven while write strobe low
    a_r3_bus_under_we: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> (fl_dq_oe && fl_addr_oe));

    // R11: done lasts one cycle
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: an accepted request makes the port busy
    a_r11_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    // R8: release mode leaves the address floating outside bus cycles
    a_r8_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_hold && fl_oe_n && fl_we_n && !fl_dq_oe) |-> !fl_addr_oe);

    // R5: recovery gap before a status read
    a_r5_recovery: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_oe_n) |-> (since_we >= T_WR));

    // R4: sector writes stay inside the join window
    a_r4_erase_window: assert property (@(posedge clk) disable iff (!rst_n)
        sect_phase |-> (win_cnt < ERASE_WIN));

endmodule

bind flash_op_seq flash_op_seq_chk #(.T_WR(T_WR)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .done       (done),
    .fl_we_n    (fl_we_n),
    .fl_oe_n    (fl_oe_n),
    .fl_dq_oe   (fl_dq_oe),
    .fl_addr_oe (fl_addr_oe),
    .mode_hold  (mode_hold),
    .sect_phase (sect_phase)
);

// File: tb/sim_flash_op_seq.sv
module sim_flash_op_seq;

    localparam int AW = 16, NSEC = 8, SEC_SHIFT = 12;
    localparam int T_SU = 2, T_WP = 3, T_H = 1, T_RD = 2;
    localparam int T_WR = 6, T_GAP = 3, MAX_POLLS = 5;
    localparam int PERIOD = T_SU + T_WP + T_H + 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_erase = 1'b0, cmd_hold = 1'b0, cmd_abort = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [7:0] cmd_data = '0;
    logic [NSEC-1:0] cmd_sectors = '0;
    logic cmd_ready, done, fl_addr_oe, fl_dq_oe, fl_we_n, fl_oe_n;
    logic [1:0] result;
    logic [AW-1:0] fl_addr;
    logic [7:0] fl_dq_out, fl_dq_in;

    always #4 clk = ~clk;

    flash_op_seq #(
        .AW(AW), .NSEC(NSEC), .SEC_SHIFT(SEC_SHIFT), .T_SU(T_SU), .T_WP(T_WP),
        .T_H(T_H), .T_RD(T_RD), .T_WR(T_WR), .T_GAP(T_GAP), .MAX_POLLS(MAX_POLLS)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_erase(cmd_erase), .cmd_hold(cmd_hold), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .cmd_sectors(cmd_sectors), .cmd_abort(cmd_abort),
        .done(done), .result(result), .fl_addr(fl_addr), .fl_addr_oe(fl_addr_oe),
        .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in),
        .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
    );

    int vectors = 0, fails = 0;
    int cyc = 0;

    // behavioural device and expectation state
    logic [AW-1:0] exp_a[$];
    logic [7:0]    exp_d[$];
    string         exp_r[$];
    int   busy_left = 0;
    logic [7:0] tgt = '0;
    logic [AW-1:0] poll_exp = '0;
    logic hold_exp = 1'b0;
    int   reads = 0;
    int   last_we_rise = 0, last_sect = -1;
    bit   poll_phase = 0, first_read = 1;
    bit   prev_we = 1, prev_oe = 1, prev_dqoe = 0, seen_low = 0;
    int   su_cnt = 0, hd_cnt = 0, lo_cnt = 0;

    assign fl_dq_in = (busy_left > 0) ? ~tgt : tgt;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
        if (rst_n) begin
            // write cycle timing and content
            if (!fl_we_n && prev_we) begin
                chk(su_cnt == T_SU, "R3 setup", su_cnt, T_SU);
                seen_low = 1;
                lo_cnt = 1;
            end else if (!fl_we_n) begin
                lo_cnt++;
            end
            if (fl_we_n && !prev_we) begin
                chk(lo_cnt == T_WP, "R3 strobe low", lo_cnt, T_WP);
                if (exp_a.size() == 0) begin
                    chk(0, "R1/R2 unexpected write", {fl_addr, fl_dq_out}, 0);
                end else begin
                    chk(fl_addr == exp_a[0], {exp_r[0], " addr"}, fl_addr, exp_a[0]);
                    chk(fl_dq_out == exp_d[0], {exp_r[0], " data"}, fl_dq_out, exp_d[0]);
                    void'(exp_a.pop_front()); void'(exp_d.pop_front()); void'(exp_r.pop_front());
                end
                if (fl_dq_out == 8'h30) begin
                    if (last_sect >= 0) chk(cyc - last_sect == PERIOD, "R4 sector spacing", cyc - last_sect, PERIOD);
                    last_sect = cyc;
                end
                last_we_rise = cyc;
            end
            if (fl_dq_oe && fl_we_n && !seen_low) su_cnt++;
            if (fl_dq_oe && fl_we_n && seen_low) hd_cnt++;
            if (!fl_dq_oe && prev_dqoe) begin
                chk(hd_cnt == T_H, "R3 hold", hd_cnt, T_H);
                su_cnt = 0; hd_cnt = 0; seen_low = 0;
                if (exp_a.size() == 0 || (exp_a.size() == 1 && exp_d[0] == 8'hF0)) poll_phase = 1;
            end
            if (fl_dq_oe && !prev_dqoe) poll_phase = 0;
            if (done) poll_phase = 0;
            // status reads
            if (!fl_oe_n && prev_oe) begin
                reads++;
                chk(fl_addr_oe && fl_addr == poll_exp, "R6/R7 poll address", fl_addr, poll_exp);
                if (first_read) begin
                    chk(cyc - last_we_rise >= T_WR, "R5 recovery", cyc - last_we_rise, T_WR);
                    first_read = 0;
                end
            end
            if (fl_oe_n && !prev_oe && busy_left > 0) busy_left--;
            // address bus ownership between cycles
            if (poll_phase && !fl_dq_oe && fl_oe_n) begin
                if (hold_exp) chk(fl_addr_oe && fl_addr == poll_exp, "R8 hold address", {fl_addr_oe, fl_addr}, {1'b1, poll_exp});
                else chk(!fl_addr_oe, "R8 release address", fl_addr_oe, 0);
            end
        end
        prev_we = fl_we_n; prev_oe = fl_oe_n; prev_dqoe = fl_dq_oe;
    end

    task automatic push(input logic [AW-1:0] a, input logic [7:0] d, input string r);
        exp_a.push_back(a); exp_d.push_back(d); exp_r.push_back(r);
    endtask

    task automatic setup(input bit erase, input logic [AW-1:0] a, input logic [7:0] d,
                         input logic [NSEC-1:0] m, input bit hold, input int busy);
        reads = 0; first_read = 1; last_sect = -1; poll_phase = 0;
        busy_left = busy; hold_exp = hold;
        if (erase) begin
            tgt = 8'hFF;
            push(16'h555, 8'hAA, "R2"); push(16'h2AA, 8'h55, "R2"); push(16'h555, 8'h80, "R2");
            push(16'h555, 8'hAA, "R2"); push(16'h2AA, 8'h55, "R2");
            poll_exp = '0;
            for (int i = NSEC - 1; i >= 0; i--) if (m[i]) poll_exp = AW'(i) << SEC_SHIFT;
            for (int i = 0; i < NSEC; i++) if (m[i]) push(AW'(i) << SEC_SHIFT, 8'h30, "R2");
        end else begin
            tgt = d; poll_exp = a;
            push(16'h555, 8'hAA, "R1"); push(16'h2AA, 8'h55, "R1");
            push(16'h555, 8'hA0, "R1"); push(a, d, "R1");
        end
        cmd_erase = erase; cmd_addr = a; cmd_data = d; cmd_sectors = m; cmd_hold = hold;
        cmd_valid = 1'b1;
    endtask

    task automatic finish_req(input int exp_res, input int exp_reads, input string req, input bit keep_valid);
        int n = 0;
        @(negedge clk);
        if (!keep_valid) cmd_valid = 1'b0;
        else begin
            chk(!cmd_ready, "R11 busy not ready", cmd_ready, 0);
            cmd_data = 8'h00;
        end
        while (!done && n < 5000) begin @(negedge clk); n++; end
        cmd_valid = 1'b0;
        chk(done, {req, " done"}, done, 1);
        chk(result == 2'(exp_res), {req, " result"}, result, exp_res);
        if (exp_reads >= 0) chk(reads == exp_reads, {req, " read count"}, reads, exp_reads);
        chk(exp_a.size() == 0, {req, " writes outstanding"}, exp_a.size(), 0);
        @(negedge clk);
        chk(!done, "R11 done one cycle", done, 0);
        exp_a.delete(); exp_d.delete(); exp_r.delete();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R13 reset state
        chk(fl_we_n && fl_oe_n, "R13 strobes", {fl_we_n, fl_oe_n}, 2'b11);
        chk(!fl_addr_oe && !fl_dq_oe, "R13 bus off", {fl_addr_oe, fl_dq_oe}, 0);
        chk(cmd_ready && !done, "R13 ready", {cmd_ready, done}, 2'b10);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R6 R8 R11: hold mode program, bit7 = 1, busy request held valid
        setup(0, 16'h1234, 8'hA5, '0, 1, 3);
        finish_req(0, 4, "R6 program hold", 1);

        // R1 R6 R8: release mode program, bit7 = 0
        setup(0, 16'h0F0F, 8'h3C, '0, 0, 2);
        finish_req(0, 3, "R6 program release", 0);

        // R2 R4 R7: release mode erase of sectors 1,2,5,7
        setup(1, '0, '0, 8'b1010_0110, 0, 4);
        finish_req(0, 5, "R7 erase release", 0);

        // R2 R7: hold mode erase of the top sector only, ready at once
        setup(1, '0, '0, 8'b1000_0000, 1, 0);
        finish_req(0, 1, "R7 erase hold", 0);

        // R12: empty sector list
        exp_a.delete();
        reads = 0;
        cmd_erase = 1; cmd_sectors = '0; cmd_valid = 1;
        finish_req(0, 0, "R12 empty erase", 0);

        // R9: device never finishes
        setup(0, 16'h0444, 8'h81, '0, 0, 100);
        push(16'h0000, 8'hF0, "R9");
        finish_req(1, MAX_POLLS, "R9 timeout", 0);
        busy_left = 0;

        // R10: abort during polling
        setup(0, 16'h0222, 8'h11, '0, 1, 100);
        push(16'h0000, 8'hF0, "R10");
        @(negedge clk); cmd_valid = 1'b0;
        begin
            int n = 0;
            while (reads < 1 && n < 2000) begin @(negedge clk); n++; end
        end
        cmd_abort = 1'b1; @(negedge clk); cmd_abort = 1'b0;
        finish_req(2, -1, "R10 abort", 0);
        busy_left = 0;

        // R10: abort while idle has no effect
        cmd_abort = 1'b1; @(negedge clk); cmd_abort = 1'b0;
        chk(cmd_ready && fl_we_n, "R10 idle abort", {cmd_ready, fl_we_n}, 2'b11);
        setup(0, 16'h0777, 8'h7E, '0, 0, 1);
        finish_req(0, 2, "R10 after idle abort", 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule